// File: doc/BRIEF.md
# Comb-Resonator Frequency Sampling Filter

This block filters a stream of real signed samples with a multiplierless frequency sampling structure. A comb of length NC subtracts the sample taken NC valid inputs earlier, which places a zero at every multiple of 360/NC degrees of normalised frequency. Up to three recursive resonators follow. Their feedback coefficients are drawn only from -1, 0 and +1, and each resonator places poles exactly on comb zeros so that the zeros cancel and a passband opens there. One resonator sits at 0 degrees, one at 180 degrees and one at +/-90 degrees. Each can be switched in by a parameter and given a sign of +1 or -1 in the output sum.

Because every pole cancels a comb zero exactly, the whole filter is a finite impulse response of length NC. All state uses wrapping two's-complement arithmetic with enough guard bits that the true result always fits. For this reason the exact cancellation never drifts, as in an integrator-comb filter. A sample is consumed on each cycle with `in_valid` high. The filtered result appears one cycle later with `out_valid` high. NC must be a multiple of 4.

Top module: `fsf_resonator_bank`

## Requirements
- R1: After NC consecutive zero-valued valid inputs, including the current one, the output of that sample is exactly zero. After reset the earlier history counts as zero.
- R2: With only the 0-degree resonator enabled and its sign positive, each output equals the sum of the last NC valid inputs, counting the current one as age 0.
- R3: With only the 180-degree resonator enabled and its sign positive, each output equals the sum over ages k from 0 to NC-1 of (-1)^k times the input of age k.
- R4: With only the 90-degree resonator enabled and its sign positive, each output equals the sum over even ages k below NC of (-1)^(k/2) times the input of age k. Odd ages do not contribute.
- R5: The output is the sum of the enabled resonator terms. Each term is negated when its NEG_* parameter is 1. The output is exact in OW = DW + clog2(NC) + 2 bits, including for full-scale inputs.
- R6: A valid input at a clock edge makes `out_valid` high in the following cycle, with `out_y` holding that sample's result. `out_valid` is low in a cycle after an edge with `in_valid` low.
- R7: A cycle with `in_valid` low leaves `out_y` unchanged and does not advance the filter history. Later results are the same as if the idle cycle had not occurred.
- R8: A synchronous reset clears `out_y` and `out_valid` to 0 and clears the comb delay line and all resonator states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_x | input | DW | Signed input sample |
| out_valid | output | 1 | Result qualifier, one cycle after `in_valid` |
| out_y | output | OW | Signed filtered result |

## Verification
The hardest situation to reach from the ports is a resonator state that wraps around its word width and must still return to exact cancellation. A related case is a long history that must come back to exactly zero after the input stops. Full-scale runs exercise this: constant most-negative input, an alternating full-scale pattern at half the sample rate, and a full-scale quarter-rate pattern. A zero tail follows each run. Long random streams with idle gaps mixed in then show that the running recursion keeps matching a direct windowed sum computed in the bench. The bench compares four copies of the filter with the same input: one per resonator, which isolates each term, and one full mix with signs.

// File: rtl/fsf_resonator_bank.sv
module fsf_resonator_bank #(
  parameter int DW = 12,
  parameter int NC = 16,
  parameter bit EN_DC = 1'b1,
  parameter bit EN_NYQ = 1'b1,
  parameter bit EN_QTR = 1'b1,
  parameter bit NEG_DC = 1'b0,
  parameter bit NEG_NYQ = 1'b1,
  parameter bit NEG_QTR = 1'b0,
  localparam int OW = DW + $clog2(NC) + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_x,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_y
);

  if (NC % 4 != 0 || NC < 4) begin : g_bad_nc
    $error("NC must be a positive multiple of 4");
  end

  logic signed [DW-1:0] dly [NC];
  logic signed [OW-1:0] acc_dc, acc_nyq, qtr_d1, qtr_d2;

  wire signed [OW-1:0] x_ext   = {{(OW-DW){in_x[DW-1]}}, in_x};
  wire signed [OW-1:0] old_ext = {{(OW-DW){dly[NC-1][DW-1]}}, dly[NC-1]};
  wire signed [OW-1:0] comb    = x_ext - old_ext;

  wire signed [OW-1:0] dc_n  = comb + acc_dc;
  wire signed [OW-1:0] nyq_n = comb - acc_nyq;
  wire signed [OW-1:0] qtr_n = comb - qtr_d2;

  wire signed [OW-1:0] t_dc  = !EN_DC  ? '0 : (NEG_DC  ? -dc_n  : dc_n);
  wire signed [OW-1:0] t_nyq = !EN_NYQ ? '0 : (NEG_NYQ ? -nyq_n : nyq_n);
  wire signed [OW-1:0] t_qtr = !EN_QTR ? '0 : (NEG_QTR ? -qtr_n : qtr_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NC; i++) dly[i] <= '0;
      acc_dc    <= '0;
      acc_nyq   <= '0;
      qtr_d1    <= '0;
      qtr_d2    <= '0;
      out_y     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dly[0] <= in_x;
        for (int i = 1; i < NC; i++) dly[i] <= dly[i-1];
        acc_dc  <= dc_n;
        acc_nyq <= nyq_n;
        qtr_d1  <= qtr_n;
        qtr_d2  <= qtr_d1;
        out_y   <= t_dc + t_nyq + t_qtr;
      end
    end
  end

endmodule

// File: rtl/fsf_checks.sv
module fsf_checks #(
  parameter int DW = 12,
  parameter int NC = 16,
  parameter int OW = 18
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic signed [DW-1:0] in_x,
  input logic                 out_valid,
  input logic signed [OW-1:0] out_y
);
  localparam int RW = $clog2(NC + 1);
  logic [RW-1:0] zero_run;

  always_ff @(posedge clk) begin
    if (rst) zero_run <= RW'(NC);
    else if (in_valid) begin
      if (in_x != '0) zero_run <= '0;
      else if (zero_run < RW'(NC)) zero_run <= zero_run + 1'b1;
    end
  end

  assert_zero_tail_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_x == '0 && zero_run >= RW'(NC - 1)) |=> (out_y == '0));

  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_drops_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_y));

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (out_y == '0 && !out_valid));
endmodule

bind fsf_resonator_bank fsf_checks #(.DW(DW), .NC(NC), .OW(OW)) u_chk (.*);

// File: tb/fsf_resonator_bank_tb.sv
module fsf_resonator_bank_tb;
  localparam int DW = 12;
  localparam int NC = 16;
  localparam int OW = DW + $clog2(NC) + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_x = '0;
  logic v_mix, v_dc, v_nyq, v_qtr;
  logic signed [OW-1:0] y_mix, y_dc, y_nyq, y_qtr;

  int nchk = 0;
  int nerr = 0;
  longint hist [NC];
  longint prev_mix, prev_dc, prev_nyq, prev_qtr;

  always #2 clk = ~clk;

  fsf_resonator_bank #(.DW(DW), .NC(NC)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
    .out_valid(v_mix), .out_y(y_mix));
  fsf_resonator_bank #(.DW(DW), .NC(NC), .EN_NYQ(1'b0), .EN_QTR(1'b0)) u_dc (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
    .out_valid(v_dc), .out_y(y_dc));
  fsf_resonator_bank #(.DW(DW), .NC(NC), .EN_DC(1'b0), .EN_QTR(1'b0),
    .NEG_NYQ(1'b0)) u_nyq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
    .out_valid(v_nyq), .out_y(y_nyq));
  fsf_resonator_bank #(.DW(DW), .NC(NC), .EN_DC(1'b0), .EN_NYQ(1'b0)) u_qtr (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
    .out_valid(v_qtr), .out_y(y_qtr));

  function automatic longint m_dc();
    longint s = 0;
    for (int k = 0; k < NC; k++) s += hist[k];
    return s;
  endfunction

  function automatic longint m_nyq();
    longint s = 0;
    for (int k = 0; k < NC; k++) s += (k % 2 == 1) ? -hist[k] : hist[k];
    return s;
  endfunction

  function automatic longint m_qtr();
    longint s = 0;
    for (int k = 0; k < NC; k += 2) s += ((k / 2) % 2 == 1) ? -hist[k] : hist[k];
    return s;
  endfunction

  function automatic bit hist_zero();
    for (int k = 0; k < NC; k++) if (hist[k] != 0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_hist();
    for (int k = 0; k < NC; k++) hist[k] = 0;
    prev_mix = 0; prev_dc = 0; prev_nyq = 0; prev_qtr = 0;
  endtask

  task automatic step(input logic v, input logic signed [DW-1:0] x);
    longint e_dc, e_nyq, e_qtr, e_mix;
    in_valid = v;
    in_x = x;
    if (v) begin
      for (int k = NC - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = longint'(x);
    end
    e_dc = m_dc(); e_nyq = m_nyq(); e_qtr = m_qtr();
    e_mix = e_dc - e_nyq + e_qtr;
    @(posedge clk);
    @(negedge clk);
    if (v) begin
      chk("R6 out_valid", longint'(v_mix), 1);
      chk("R2 dc term", longint'(y_dc), e_dc);
      chk("R3 nyquist term", longint'(y_nyq), e_nyq);
      chk("R4 quarter term", longint'(y_qtr), e_qtr);
      if (hist_zero()) chk("R1 zero tail", longint'(y_mix), 0);
      else chk("R5 signed sum", longint'(y_mix), e_mix);
      prev_mix = longint'(y_mix); prev_dc = longint'(y_dc);
      prev_nyq = longint'(y_nyq); prev_qtr = longint'(y_qtr);
    end else begin
      chk("R6 out_valid low", longint'(v_mix), 0);
      chk("R7 idle hold mix", longint'(y_mix), prev_mix);
      chk("R7 idle hold dc", longint'(y_dc), prev_dc);
      chk("R7 idle hold nyq", longint'(y_nyq), prev_nyq);
      chk("R7 idle hold qtr", longint'(y_qtr), prev_qtr);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset out_y", longint'(y_mix), 0);
    chk("R8 reset out_valid", longint'(v_mix), 0);
    chk("R8 reset dc", longint'(y_dc), 0);
    rst = 1'b0;
    clear_hist();
  endtask

  initial begin
    #(4 * 200000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    clear_hist();
    @(negedge clk);
    do_reset();

    step(1'b1, 12'sd1000);
    for (int i = 0; i < NC + 4; i++) step(1'b1, '0);

    for (int i = 0; i < NC + 4; i++) step(1'b1, -12'sd2048);
    for (int i = 0; i < NC + 2; i++) step(1'b1, '0);

    for (int i = 0; i < NC + 4; i++) step(1'b1, (i % 2 == 0) ? 12'sd2047 : -12'sd2048);
    for (int i = 0; i < NC + 2; i++) step(1'b1, '0);

    for (int i = 0; i < NC + 8; i++)
      step(1'b1, (i % 4 == 0) ? 12'sd2047 : ((i % 4 == 2) ? -12'sd2048 : 12'sd0));
    for (int i = 0; i < NC + 2; i++) step(1'b1, '0);

    for (int i = 0; i < 600; i++) begin
      logic v;
      v = ($urandom % 4) != 0;
      step(v, DW'($urandom));
    end

    for (int i = 0; i < 40; i++) step(1'b1, DW'($urandom));
    do_reset();
    step(1'b1, '0);
    step(1'b1, 12'sd5);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule